// File: doc/BRIEF.md
# Paged Split-Offset Address Translator

This block turns a register value into a physical data-memory address for loads and stores on a 36-bit word machine. A user access looks up its virtual page in a 2048-entry page table. The table returns a physical page and a protect flag, and these replace the upper address bits. A privileged access skips the table and uses its own upper bits unchanged. Supervisor logic fills the table through a separate synchronous write port.

When add mode is on, the translator also forms a cheap base-plus-offset address. The low twelve bits are split into two 6-bit fields. Each field adds the matching offset field and wraps on its own, so no carry crosses between the fields or into the page bits. The addition runs in parallel with the table lookup. Software that keeps its structures inside 64-word or aligned power-of-two blocks gets a correct base-plus-offset read in a single operation.

Every output is registered and appears one clock after the request. The write-permitted flag is low whenever bit 35 of the address is set, because that bit selects the read-only alias of a word.

Top module: `paged_xlat`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `req_i` high, and low otherwise.
- R2: With `add_i` high, `paddr_o[5:0]` equals `(base_i[5:0] + ofs_i[5:0]) mod 64`.
- R3: With `add_i` high, `paddr_o[11:6]` equals `(base_i[11:6] + ofs_i[11:6]) mod 64`. A carry out of either field is dropped: it never reaches bit 6 or bit 12.
- R4: With `add_i` low, `paddr_o[11:0]` equals `base_i[11:0]`, and `ofs_i` has no effect on the address.
- R5: For a user access (`priv_i` low), `paddr_o[34:12]` is the physical page and `paddr_o[35]` is the protect flag of the entry selected by `base_i[22:12]`. Base bits 35..23 have no effect.
- R6: For a privileged access (`priv_i` high), `paddr_o[35:12]` equals `base_i[35:12]`, and the table contents have no effect.
- R7: On a valid cycle, `wr_ok_o` is the inverse of `paddr_o[35]`.
- R8: A table write takes effect at the clock edge. A request in the same cycle as a write to the same entry sees the old entry. A request in a later cycle sees the new entry.
- R9: After reset, `valid_o`, `wr_ok_o` and `paddr_o` are zero, and every table entry holds page 0 with its protect flag clear.
- R10: In a cycle after one with no request, `paddr_o` and `wr_ok_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request strobe |
| priv_i | input | 1 | Privileged access; bypasses the page table |
| add_i | input | 1 | Enables the split offset addition |
| base_i | input | 36 | Base address register value |
| ofs_i | input | 36 | Offset register value; only bits 11..0 are used |
| pt_we_i | input | 1 | Page-table write enable |
| pt_idx_i | input | 11 | Page-table entry to write |
| pt_page_i | input | 23 | Physical page to write |
| pt_prot_i | input | 1 | Protect flag to write |
| paddr_o | output | 36 | Registered physical address |
| wr_ok_o | output | 1 | Registered write-permitted flag |
| valid_o | output | 1 | Result valid, one cycle after the request |

## Verification
The assertions assume that the control inputs and the base and offset values are known (never X) in every cycle with `req_i` high. They also assume that reset is applied before the first request. The checker compares each registered result with the inputs of the previous cycle, so it needs no further limits on the order of requests and table writes. The bench drives all inputs with known values on the falling edge in every cycle, and holds reset for several cycles before the first stimulus. Its random cycles freely mix table writes, requests, idle cycles, both modes and both add settings. It also aims some requests at recently written entries, so that the same-cycle write case comes up often.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int WORD_W   = 36;
  localparam int FIELD_W  = 6;
  localparam int N_FIELDS = 2;
  localparam int LOW_W    = FIELD_W * N_FIELDS;
  localparam int VPN_W    = 11;
  localparam int PPN_W    = WORD_W - 1 - LOW_W;
endpackage

// File: rtl/xlat_split_add.sv
module xlat_split_add #(
  parameter int FIELD_W  = 6,
  parameter int N_FIELDS = 2,
  localparam int LOW_W   = FIELD_W * N_FIELDS
) (
  input  logic             en_i,
  input  logic [LOW_W-1:0] a_i,
  input  logic [LOW_W-1:0] b_i,
  output logic [LOW_W-1:0] y_o
);
  // each field wraps independently, carries are dropped
  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    logic [FIELD_W-1:0] sum;
    assign sum = a_i[f*FIELD_W +: FIELD_W] + b_i[f*FIELD_W +: FIELD_W];
    assign y_o[f*FIELD_W +: FIELD_W] = en_i ? sum : a_i[f*FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/xlat_page_table.sv
module xlat_page_table #(
  parameter int VPN_W = 11,
  parameter int PPN_W = 23,
  localparam int DEPTH = 1 << VPN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VPN_W-1:0] widx_i,
  input  logic [PPN_W-1:0] wpage_i,
  input  logic             wprot_i,
  input  logic [VPN_W-1:0] ridx_i,
  output logic [PPN_W-1:0] rpage_o,
  output logic             rprot_o
);
  logic [PPN_W:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= {wprot_i, wpage_i};
    end
  end

  // read sees contents before any write at this edge
  assign {rprot_o, rpage_o} = mem_q[ridx_i];
endmodule

// File: rtl/paged_xlat.sv
module paged_xlat
  import xlat_pkg::*;
#(
  parameter int W   = WORD_W,
  parameter int FW  = FIELD_W,
  parameter int NF  = N_FIELDS,
  parameter int VW  = VPN_W,
  localparam int LW = FW * NF,
  localparam int PW = W - 1 - LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          priv_i,
  input  logic          add_i,
  input  logic [W-1:0]  base_i,
  input  logic [W-1:0]  ofs_i,
  input  logic          pt_we_i,
  input  logic [VW-1:0] pt_idx_i,
  input  logic [PW-1:0] pt_page_i,
  input  logic          pt_prot_i,
  output logic [W-1:0]  paddr_o,
  output logic          wr_ok_o,
  output logic          valid_o
);
  logic [LW-1:0] low_d;
  logic [PW-1:0] pg_page;
  logic          pg_prot;
  logic [W-1:0]  addr_d;
  logic [W-1:0]  addr_q;
  logic          wr_ok_q, valid_q;

  xlat_split_add #(.FIELD_W(FW), .N_FIELDS(NF)) u_add (
    .en_i (add_i),
    .a_i  (base_i[LW-1:0]),
    .b_i  (ofs_i[LW-1:0]),
    .y_o  (low_d)
  );

  xlat_page_table #(.VPN_W(VW), .PPN_W(PW)) u_pt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pt_we_i),
    .widx_i  (pt_idx_i),
    .wpage_i (pt_page_i),
    .wprot_i (pt_prot_i),
    .ridx_i  (base_i[LW +: VW]),
    .rpage_o (pg_page),
    .rprot_o (pg_prot)
  );

  always_comb begin
    if (priv_i) addr_d = {base_i[W-1:LW], low_d};
    else        addr_d = {pg_prot, pg_page, low_d};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wr_ok_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        addr_q  <= addr_d;
        wr_ok_q <= ~addr_d[W-1];
      end
    end
  end

  assign paddr_o = addr_q;
  assign wr_ok_o = wr_ok_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/paged_xlat_chk.sv
module paged_xlat_chk
  import xlat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              priv_i,
  input logic              add_i,
  input logic [WORD_W-1:0] base_i,
  input logic [WORD_W-1:0] ofs_i,
  input logic [WORD_W-1:0] paddr_o,
  input logic              wr_ok_o,
  input logic              valid_o
);
  logic [FIELD_W-1:0] lo_sum, hi_sum;
  assign lo_sum = base_i[FIELD_W-1:0] + ofs_i[FIELD_W-1:0];
  assign hi_sum = base_i[2*FIELD_W-1:FIELD_W] + ofs_i[2*FIELD_W-1:FIELD_W];

  assert_valid_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(req_i));

  assert_low_field_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && add_i |=> paddr_o[FIELD_W-1:0] == $past(lo_sum));

  assert_high_field_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && add_i |=> paddr_o[2*FIELD_W-1:FIELD_W] == $past(hi_sum));

  assert_pass_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !add_i |=> paddr_o[LOW_W-1:0] == $past(base_i[LOW_W-1:0]));

  assert_priv_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && priv_i |=> paddr_o[WORD_W-1:LOW_W] == $past(base_i[WORD_W-1:LOW_W]));

  assert_wr_ok_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> wr_ok_o == !paddr_o[WORD_W-1]);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(paddr_o) && $stable(wr_ok_o));
endmodule

bind paged_xlat paged_xlat_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .priv_i  (priv_i),
  .add_i   (add_i),
  .base_i  (base_i),
  .ofs_i   (ofs_i),
  .paddr_o (paddr_o),
  .wr_ok_o (wr_ok_o),
  .valid_o (valid_o)
);

// File: tb/paged_xlat_bench.sv
`timescale 1ns/1ps
module paged_xlat_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, priv_i = 1'b0, add_i = 1'b0;
  logic [35:0] base_i = '0, ofs_i = '0;
  logic        pt_we_i = 1'b0;
  logic [10:0] pt_idx_i = '0;
  logic [22:0] pt_page_i = '0;
  logic        pt_prot_i = 1'b0;
  logic [35:0] paddr_o;
  logic        wr_ok_o, valid_o;

  int n_chk = 0, n_bad = 0;
  logic [23:0] shadow [2048];
  logic [35:0] last_addr = '0;
  logic        last_ok = 1'b0;
  bit          done = 0;

  always #10 clk_i = ~clk_i;

  paged_xlat u_paged_xlat (.*);

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] model(input logic pv, input logic ad,
                                        input logic [35:0] b, input logic [35:0] o);
    logic [5:0] lo, hi;
    logic [23:0] e;
    lo = ad ? b[5:0] + o[5:0] : b[5:0];
    hi = ad ? b[11:6] + o[11:6] : b[11:6];
    e  = shadow[b[22:12]];
    return pv ? {b[35:12], hi, lo} : {e, hi, lo};
  endfunction

  task automatic cyc(input logic rq, input logic pv, input logic ad,
                     input logic [35:0] b, input logic [35:0] o,
                     input logic we, input logic [10:0] wi,
                     input logic [22:0] wp, input logic wpr, input string tag);
    logic [35:0] exp;
    @(negedge clk_i);
    req_i = rq; priv_i = pv; add_i = ad; base_i = b; ofs_i = o;
    pt_we_i = we; pt_idx_i = wi; pt_page_i = wp; pt_prot_i = wpr;
    exp = rq ? model(pv, ad, b, o) : last_addr;
    @(posedge clk_i);
    #2;
    if (we) shadow[wi] = {wpr, wp};
    chk({"R1 valid ", tag}, {35'd0, valid_o}, {35'd0, rq});
    chk({tag, " addr"}, paddr_o, exp);
    chk({"R7/R10 wr_ok ", tag}, {35'd0, wr_ok_o}, {35'd0, rq ? ~exp[35] : last_ok});
    last_addr = exp;
    if (rq) last_ok = ~exp[35];
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 2048; i++) shadow[i] = '0;
    repeat (3) @(posedge clk_i);
    #2;
    chk("R9 reset valid", {35'd0, valid_o}, 36'd0);
    chk("R9 reset addr", paddr_o, 36'd0);
    chk("R9 reset wr_ok", {35'd0, wr_ok_o}, 36'd0);
    rst_ni = 1'b1;

    // R9 entries zero after reset
    cyc(1, 0, 0, 36'hF_F800_5ABC, '0, 0, '0, '0, 0, "R9 R5 reset entry");
    // R5 user page from table, protect set, high base bits ignored
    cyc(0, 0, 0, '0, '0, 1, 11'd5, 23'h12_3456, 1, "R10 idle write");
    cyc(1, 0, 0, 36'h0_0000_5123, '0, 0, '0, '0, 0, "R5 prot entry");
    cyc(1, 0, 0, 36'hF_FF80_5123, '0, 0, '0, '0, 0, "R5 upper ignored");
    // R2 low field wraps, no carry into high field
    cyc(1, 1, 1, 36'h0_0000_003F, 36'h1, 0, '0, '0, 0, "R2 low wrap");
    // R3 high field wraps, no carry into page bits
    cyc(1, 1, 1, 36'h0_0000_0FC0, 36'h40, 0, '0, '0, 0, "R3 high wrap");
    cyc(1, 0, 1, 36'h0_0000_5FFF, 36'hFFF, 0, '0, '0, 0, "R3 both wrap user");
    // R4 offset ignored
    cyc(1, 1, 0, 36'h8_1234_5678, 36'hF_FFFF_FFFF, 0, '0, '0, 0, "R4 offset ignored");
    // R6 privileged bypasses table, bit 35 set -> no write
    cyc(1, 1, 0, 36'h8_0000_5000, '0, 0, '0, '0, 0, "R6 priv bypass");
    // R8 same-cycle write returns old entry, next cycle new
    cyc(1, 0, 0, 36'h0_0000_7001, '0, 1, 11'd7, 23'h7A_BCDE, 0, "R8 same cycle old");
    cyc(1, 0, 0, 36'h0_0000_7001, '0, 0, '0, '0, 0, "R8 next cycle new");
    cyc(0, 0, 0, 36'h0_0000_7001, 36'h5, 0, '0, '0, 0, "R10 hold");

    for (int n = 0; n < 4000; n++) begin
      logic [35:0] b;
      logic [10:0] wi;
      b  = {$urandom, $urandom};
      wi = ($urandom % 4 == 0) ? b[22:12] : 11'($urandom);
      cyc(($urandom % 5) != 0, $urandom % 4 == 0, $urandom % 2 == 1, b,
          {$urandom, $urandom}, $urandom % 3 == 0, wi, 23'($urandom),
          $urandom % 2 == 1, "R2 R3 R4 R5 R6 R8 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule